// File: doc/BRIEF.md
# Streaming TLP Transmit Source

This block sits on the application side of a PCIe transaction layer and feeds packets into a valid/ready streaming sink whose ready signal takes effect two cycles late. Each packet already sits in a local dword buffer: a 3- or 4-dword header followed by the payload dwords. The packet is described to the block by its base address, total dword count and header size. The block then reads the buffer beat by beat through a combinational read port and places each beat on the stream with start and end markers. On the 128-bit bus it also marks an empty upper qword on the last beat.

The lane count is a parameter: 2 dwords per beat for a 64-bit bus, 4 dwords for a 128-bit bus. A packet may ask to be nullified. The block then raises the error flag on the second beat, as long as the packet is long enough and carries a payload. A request that does not qualify is dropped and recorded in a sticky flag. Packets can follow one another with no idle cycle, except right after a nullified packet, which is always followed by at least one idle cycle.

Top module: `tlp_tx_source`

## Requirements
- R1: `tx_valid` is high only while a packet is in flight and `tx_ready` was high two clock edges earlier. It falls two cycles after `tx_ready` falls and rises again two cycles after `tx_ready` returns.
- R2: While a packet is in flight and `tx_valid` is low, `rd_addr` (and with it `tx_data`) stays unchanged.
- R3: Beat k of a packet carries buffer dwords base+k*LANES onward, with the lowest-addressed dword in bits [31:0]. On the 64-bit bus a 4-dword header therefore fills beats 0 and 1, and the payload starts in beat 2.
- R4: A packet of D dwords takes ceil(D/LANES) accepted beats. `tx_sop` marks the first beat and `tx_eop` the last, both only together with `tx_valid`.
- R5: `tx_empty` is 1 only at `tx_eop` on the 128-bit bus, when the last beat holds 1 or 2 dwords (D mod 4 is 1 or 2), meaning the upper qword is unused. It is always 0 on the 64-bit bus.
- R6: For a granted nullify, `tx_err` is high for exactly one cycle, together with the accepted second beat (index 1). That beat is neither sop nor eop.
- R7: A nullify request is granted only if the packet has at least 3 beats and a payload (D greater than the header size: 4 when `pkt_hdr4`=1, else 3). Otherwise `tx_err` stays low for the packet and `null_rej` is set and stays 1 until reset.
- R8: `pkt_ready` is high when idle and during the cycle in which the eop beat of a non-nullified packet is accepted. A packet started in that cycle has its sop on the very next cycle.
- R9: During the eop cycle of a nullified packet `pkt_ready` is low, so the next sop comes at least two cycles after that eop.
- R10: After reset `tx_valid`, `tx_sop`, `tx_eop`, `tx_empty`, `tx_err` and `null_rej` are 0 and `pkt_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_ready | input | 1 | Sink ready, effective two cycles later |
| pkt_start | input | 1 | Start a packet (taken when `pkt_ready` is high) |
| pkt_base | input | AW | Buffer dword address of header dword 0 |
| pkt_dwords | input | LW | Total dwords, header plus payload (at least 3) |
| pkt_hdr4 | input | 1 | Header is 4 dwords (else 3) |
| pkt_nullify | input | 1 | Request nullification of this packet |
| pkt_ready | output | 1 | Block can take a packet this cycle |
| rd_addr | output | AW | Buffer address of the current beat's first dword |
| rd_data | input | LANES*32 | Buffer dwords rd_addr onward, lowest in bits [31:0] |
| tx_data | output | LANES*32 | Stream data |
| tx_valid | output | 1 | Stream valid |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| tx_empty | output | 1 | Upper qword unused at eop (128-bit only) |
| tx_err | output | 1 | Nullify marker |
| null_rej | output | 1 | Sticky: a nullify request was refused |

## Verification
Both bus widths run side by side against a behavioural model that is checked every cycle. Three ready patterns are used. A steady-high phase exposes back-to-back framing and the idle cycle that must follow a nullified packet. A pseudo-random phase shows whether valid tracks ready exactly two cycles late and whether the read address holds through stalls. A periodic on/off phase catches stalls that land on the sop, the second beat and the eop. The packet mix covers header-only, odd and even dword counts, nullify requests that are granted, and nullify requests that are refused on only one of the two widths. The refused cases show that the 3-beat and payload rules are applied per width.

// File: rtl/tlp_tx_pkg.sv
// Shared constants and helpers for the streaming TLP transmit source.
// Assumes dword-granular buffers and a power-of-two lane count.
package tlp_tx_pkg;
    localparam int DWORD_W   = 32;
    localparam int HDR3_DW   = 3;
    localparam int HDR4_DW   = 4;
    localparam int MIN_NULL_BEATS = 3;
endpackage

// File: rtl/tlp_rdy_delay.sv
// Delays the sink ready by DEPTH register stages so that the sequencer
// sees ready at the cycle in which a beat may legally be presented.
// Assumes DEPTH >= 1.
module tlp_rdy_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_in,
    output logic rdy_late
);
    logic [DEPTH-1:0] stg_q;

    generate
        if (DEPTH == 1) begin : g_single
            // one-stage delay
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= rdy_in;
            end
        end else begin : g_chain
            // shift ready through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[DEPTH-2:0], rdy_in};
            end
        end
    endgenerate

    assign rdy_late = stg_q[DEPTH-1];
endmodule

// File: rtl/tlp_beat_seq.sv
// Packet and beat sequencer: accepts a packet descriptor, walks its beats
// through the buffer, advances only on accepted beats, decides whether a
// nullify request is allowed and keeps a sticky refusal flag.
// Assumes pkt_dwords >= 3 and that the descriptor is valid with pkt_start.
module tlp_beat_seq
    import tlp_tx_pkg::*;
#(
    parameter int LANES = 2,
    parameter int AW    = 10,
    parameter int LW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rdy_late,
    input  logic          pkt_start,
    input  logic [AW-1:0] pkt_base,
    input  logic [LW-1:0] pkt_dwords,
    input  logic          pkt_hdr4,
    input  logic          pkt_nullify,
    output logic          pkt_ready,
    output logic          busy,
    output logic          fire,
    output logic          at_first,
    output logic          at_second,
    output logic          at_last,
    output logic          last_short,
    output logic          null_on,
    output logic          null_rej,
    output logic [AW-1:0] rd_addr
);
    localparam int LSH = $clog2(LANES);

    logic          busy_q;
    logic [LW-1:0] beat_q;
    logic [LW-1:0] nbeats_q;
    logic [AW-1:0] base_q;
    logic [LSH-1:0] tail_q;
    logic          nul_q;
    logic          rej_q;

    logic [LW-1:0] nbeats_in;
    logic [LW-1:0] hdr_dw;
    logic          grant;
    logic          done;
    logic          accept;

    // descriptor decode: beat count and nullify eligibility
    always_comb begin
        nbeats_in = LW'((pkt_dwords + LW'(LANES - 1)) >> LSH);
        hdr_dw    = pkt_hdr4 ? LW'(HDR4_DW) : LW'(HDR3_DW);
        grant     = pkt_nullify && (nbeats_in >= LW'(MIN_NULL_BEATS)) && (pkt_dwords > hdr_dw);
    end

    // beat acceptance and packet hand-over
    always_comb begin
        fire      = busy_q && rdy_late;
        at_last   = busy_q && (beat_q == nbeats_q - LW'(1));
        at_first  = busy_q && (beat_q == '0);
        at_second = busy_q && (beat_q == LW'(1));
        done      = fire && at_last;
        pkt_ready = !busy_q || (done && !nul_q);
        accept    = pkt_start && pkt_ready;
    end

    // packet state: load on accept, step on accepted beats, retire on eop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            beat_q   <= '0;
            nbeats_q <= '0;
            base_q   <= '0;
            tail_q   <= '0;
            nul_q    <= 1'b0;
        end else if (accept) begin
            busy_q   <= 1'b1;
            beat_q   <= '0;
            nbeats_q <= nbeats_in;
            base_q   <= pkt_base;
            tail_q   <= pkt_dwords[LSH-1:0];
            nul_q    <= grant;
        end else if (done) begin
            busy_q   <= 1'b0;
        end else if (fire) begin
            beat_q   <= beat_q + LW'(1);
        end
    end

    // sticky record of refused nullify requests
    always_ff @(posedge clk) begin
        if (!rst_n)                                 rej_q <= 1'b0;
        else if (accept && pkt_nullify && !grant)   rej_q <= 1'b1;
    end

    assign busy       = busy_q;
    assign null_on    = nul_q;
    assign null_rej   = rej_q;
    assign last_short = (tail_q != '0) && ({1'b0, tail_q} <= (LSH + 1)'(LANES / 2));
    assign rd_addr    = base_q + AW'({beat_q, {LSH{1'b0}}});

    // R9: a nullified packet leaves the block idle for the next cycle
    a_r9_idle_after_null: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && at_last && nul_q) |=> !busy_q);
    // R7: refusal flag never clears outside reset
    a_r7_sticky_refusal: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rej_q) |-> rej_q);
endmodule

// File: rtl/tlp_frame_out.sv
// Framing stage: turns the sequencer's beat position into stream valid,
// start/end markers, the empty-qword flag and the nullify marker.
// Assumes empty applies only when LANES is 4 (128-bit bus).
module tlp_frame_out #(
    parameter int LANES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic at_first,
    input  logic at_second,
    input  logic at_last,
    input  logic last_short,
    input  logic null_on,
    output logic tx_valid,
    output logic tx_sop,
    output logic tx_eop,
    output logic tx_empty,
    output logic tx_err
);
    localparam bit WIDE = (LANES > 2);

    // markers qualified by an accepted beat
    always_comb begin
        tx_valid = fire;
        tx_sop   = fire && at_first;
        tx_eop   = fire && at_last;
        tx_empty = WIDE && fire && at_last && last_short;
        tx_err   = fire && null_on && at_second;
    end

    // R6: nullify marker never shares a beat with sop or eop
    a_r6_err_inside: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> (tx_valid && !tx_sop && !tx_eop));
    // R5: empty only on an eop beat
    a_r5_empty_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_eop);
endmodule

// File: rtl/tlp_tx_source.sv
// Streaming TLP transmit source: reads a packet from a local dword buffer
// and drives it onto a valid/ready stream whose ready has a two-cycle
// latency, with sop/eop, empty-qword and nullify marking.
// Assumes rd_data is a combinational read of rd_addr and LANES is 2 or 4.
module tlp_tx_source
    import tlp_tx_pkg::*;
#(
    parameter int LANES     = 2,
    parameter int AW        = 10,
    parameter int LW        = 11,
    parameter int RDY_LAT   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_ready,
    input  logic                     pkt_start,
    input  logic [AW-1:0]            pkt_base,
    input  logic [LW-1:0]            pkt_dwords,
    input  logic                     pkt_hdr4,
    input  logic                     pkt_nullify,
    output logic                     pkt_ready,
    output logic [AW-1:0]            rd_addr,
    input  logic [LANES*DWORD_W-1:0] rd_data,
    output logic [LANES*DWORD_W-1:0] tx_data,
    output logic                     tx_valid,
    output logic                     tx_sop,
    output logic                     tx_eop,
    output logic                     tx_empty,
    output logic                     tx_err,
    output logic                     null_rej
);
    logic rdy_late;
    logic busy, fire, at_first, at_second, at_last, last_short, null_on;

    tlp_rdy_delay #(.DEPTH(RDY_LAT)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdy_in   (tx_ready),
        .rdy_late (rdy_late)
    );

    tlp_beat_seq #(.LANES(LANES), .AW(AW), .LW(LW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rdy_late    (rdy_late),
        .pkt_start   (pkt_start),
        .pkt_base    (pkt_base),
        .pkt_dwords  (pkt_dwords),
        .pkt_hdr4    (pkt_hdr4),
        .pkt_nullify (pkt_nullify),
        .pkt_ready   (pkt_ready),
        .busy        (busy),
        .fire        (fire),
        .at_first    (at_first),
        .at_second   (at_second),
        .at_last     (at_last),
        .last_short  (last_short),
        .null_on     (null_on),
        .null_rej    (null_rej),
        .rd_addr     (rd_addr)
    );

    tlp_frame_out #(.LANES(LANES)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .at_first   (at_first),
        .at_second  (at_second),
        .at_last    (at_last),
        .last_short (last_short),
        .null_on    (null_on),
        .tx_valid   (tx_valid),
        .tx_sop     (tx_sop),
        .tx_eop     (tx_eop),
        .tx_empty   (tx_empty),
        .tx_err     (tx_err)
    );

    // buffer beat passes straight to the stream
    assign tx_data = rd_data;

    // R1: valid only when ready was seen two edges earlier
    a_r1_valid_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_ready, 2));
    // R2: beat position held across a stall
    a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_valid) |=> $stable(rd_addr));
    // R4: markers only on valid beats
    a_r4_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sop || tx_eop) |-> tx_valid);
endmodule

// File: tb/tlp_tx_source_test.sv
`timescale 1ns/1ps
// Behavioural reference of the transmit source for one lane count.
module tlp_tx_ref #(parameter int L = 2) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ready,
    input  logic        start,
    input  int          base,
    input  int          dwords,
    input  logic        hdr4,
    input  logic        nreq,
    output logic        e_busy,
    output logic        e_valid,
    output logic        e_sop,
    output logic        e_eop,
    output logic        e_empty,
    output logic        e_err,
    output logic        e_prdy,
    output logic        e_rej,
    output int          e_addr
);
    int rq[$];
    int busy, beat, nb, dws, bs, nul, rej;
    int late, fire, last, prdy, g, nbi, hd;

    always @(posedge clk) begin
        if (!rst_n) begin
            rq = {}; busy = 0; beat = 0; nb = 0; dws = 0; bs = 0; nul = 0; rej = 0;
        end else begin
            late = (rq.size() >= 2) ? rq[rq.size()-2] : 0;
            fire = busy && late;
            last = (beat == nb - 1);
            prdy = !busy || (fire && last && !nul);
            if (start && prdy) begin
                nbi = (dwords + L - 1) / L;
                hd  = hdr4 ? 4 : 3;
                g   = nreq && nbi >= 3 && dwords > hd;
                if (nreq && !g) rej = 1;
                busy = 1; beat = 0; nb = nbi; dws = dwords; bs = base; nul = g;
            end else if (fire && last) busy = 0;
            else if (fire) beat++;
            rq.push_back(ready ? 1 : 0);
            if (rq.size() > 2) void'(rq.pop_front());
        end
    end

    always_comb begin
        late    = (rq.size() >= 2) ? rq[0] : 0;
        e_busy  = busy != 0;
        e_valid = (busy != 0) && (late != 0);
        e_sop   = e_valid && beat == 0;
        e_eop   = e_valid && beat == nb - 1;
        e_empty = (L == 4) && e_eop && ((dws % 4) == 1 || (dws % 4) == 2);
        e_err   = e_valid && (nul != 0) && beat == 1;
        e_prdy  = (busy == 0) || (e_eop && nul == 0);
        e_rej   = rej != 0;
        e_addr  = (bs + beat * L) % 1024;
    end
endmodule

module tlp_tx_source_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct { int base; int dws; bit h4; bit nr; } cmd_t;

    logic rst_n = 1'b0;
    logic tx_ready = 1'b0;
    logic [31:0] mem [0:1023];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    cmd_t qa[$];
    cmd_t qb[$];

    // narrow (64-bit) instance signals
    logic sa = 0, ha = 0, na = 0; logic [9:0] ba = 0; logic [10:0] da = 3;
    logic pra, va, spa, epa, ema, era, rja; logic [9:0] raa;
    logic [63:0] rda, tda;
    // wide (128-bit) instance signals
    logic sb = 0, hb = 0, nb = 0; logic [9:0] bb = 0; logic [10:0] db = 3;
    logic prb, vb, spb, epb, emb, erb, rjb; logic [9:0] rab;
    logic [127:0] rdb, tdb;

    assign rda = {mem[raa + 10'd1], mem[raa]};
    assign rdb = {mem[rab + 10'd3], mem[rab + 10'd2], mem[rab + 10'd1], mem[rab]};

    tlp_tx_source #(.LANES(2)) uut (
        .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .pkt_start(sa), .pkt_base(ba),
        .pkt_dwords(da), .pkt_hdr4(ha), .pkt_nullify(na), .pkt_ready(pra), .rd_addr(raa),
        .rd_data(rda), .tx_data(tda), .tx_valid(va), .tx_sop(spa), .tx_eop(epa),
        .tx_empty(ema), .tx_err(era), .null_rej(rja));

    tlp_tx_source #(.LANES(4)) uut4 (
        .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .pkt_start(sb), .pkt_base(bb),
        .pkt_dwords(db), .pkt_hdr4(hb), .pkt_nullify(nb), .pkt_ready(prb), .rd_addr(rab),
        .rd_data(rdb), .tx_data(tdb), .tx_valid(vb), .tx_sop(spb), .tx_eop(epb),
        .tx_empty(emb), .tx_err(erb), .null_rej(rjb));

    logic xba, xva, xsa, xea, xma, xra, xpa, xja; int xaa;
    logic xbb, xvb, xsb, xeb, xmb, xrb, xpb, xjb; int xab;

    tlp_tx_ref #(.L(2)) ref_a (.clk(clk), .rst_n(rst_n), .ready(tx_ready), .start(sa),
        .base(int'(ba)), .dwords(int'(da)), .hdr4(ha), .nreq(na), .e_busy(xba), .e_valid(xva),
        .e_sop(xsa), .e_eop(xea), .e_empty(xma), .e_err(xra), .e_prdy(xpa), .e_rej(xja), .e_addr(xaa));
    tlp_tx_ref #(.L(4)) ref_b (.clk(clk), .rst_n(rst_n), .ready(tx_ready), .start(sb),
        .base(int'(bb)), .dwords(int'(db)), .hdr4(hb), .nreq(nb), .e_busy(xbb), .e_valid(xvb),
        .e_sop(xsb), .e_eop(xeb), .e_empty(xmb), .e_err(xrb), .e_prdy(xpb), .e_rej(xjb), .e_addr(xab));

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic add(input int base, input bit h4, input int pay, input bit nr);
        cmd_t c;
        c.base = base; c.h4 = h4; c.dws = (h4 ? 4 : 3) + pay; c.nr = nr;
        qa.push_back(c); qb.push_back(c);
    endtask

    task automatic compare_all();
        logic [9:0] ia, ib;
        ia = 10'(xaa); ib = 10'(xab);
        chk("R1", "valid64", va, xva);            chk("R1", "valid128", vb, xvb);
        chk("R4", "sop64", spa, xsa);             chk("R4", "sop128", spb, xsb);
        chk("R4", "eop64", epa, xea);             chk("R4", "eop128", epb, xeb);
        chk("R5", "empty64", ema, xma);           chk("R5", "empty128", emb, xmb);
        chk("R6", "err64", era, xra);             chk("R6", "err128", erb, xrb);
        chk("R8 R9", "pkt_ready64", pra, xpa);    chk("R8 R9", "pkt_ready128", prb, xpb);
        chk("R7", "null_rej64", rja, xja);        chk("R7", "null_rej128", rjb, xjb);
        if (xba) chk("R2", "rd_addr64", raa, ia);
        if (xbb) chk("R2", "rd_addr128", rab, ib);
        if (xva) chk("R3", "data64", tda, {mem[ia + 10'd1], mem[ia]});
        if (xvb) chk("R3", "data128", tdb, {mem[ib + 10'd3], mem[ib + 10'd2], mem[ib + 10'd1], mem[ib]});
    endtask

    // watchdog: a hung run ends as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lf;
        cmd_t c;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA5000000 ^ (i * 32'h00010003);
        for (int r = 0; r < 4; r++) begin
            add(0,   1, 0, 0);   // header only, 4 dwords
            add(16,  0, 1, 0);   // 4 dwords
            add(32,  0, 3, 0);   // 6 dwords: wide eop with upper qword empty
            add(64,  1, 8, 1);   // nullify granted on both widths
            add(100, 0, 2, 0);   // right after a nullified packet
            add(120, 0, 0, 1);   // no payload: refused
            add(140, 1, 2, 1);   // 3 beats narrow (granted), 2 beats wide (refused)
            add(200, 1, 5, 0);   // 9 dwords
            add(300, 0, 4, 1);   // 7 dwords: narrow granted, wide refused
            add(400, 0, 6, 1);   // 9 dwords: granted on both
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10", "valid64", va, 1'b0);      chk("R10", "valid128", vb, 1'b0);
        chk("R10", "pkt_ready64", pra, 1'b1); chk("R10", "pkt_ready128", prb, 1'b1);
        chk("R10", "null_rej64", rja, 1'b0);  chk("R10", "err128", erb, 1'b0);
        lf = 32'h1ACE;
        for (int n = 0; n < 3000; n++) begin
            compare_all();
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
            if (n < 400)       tx_ready = 1'b1;
            else if (n < 1600) tx_ready = (lf & 3) != 0;
            else               tx_ready = ((n % 5) < 3);
            // descriptors are offered only when the reference expects acceptance
            if (qa.size() > 0 && xpa && (n < 400 || (lf & 8) == 0)) begin
                c = qa.pop_front(); sa = 1; ba = 10'(c.base); da = 11'(c.dws); ha = c.h4; na = c.nr;
            end else sa = 0;
            if (qb.size() > 0 && xpb && (n < 400 || (lf & 16) == 0)) begin
                c = qb.pop_front(); sb = 1; bb = 10'(c.base); db = 11'(c.dws); hb = c.h4; nb = c.nr;
            end else sb = 0;
            @(negedge clk);
            cyc++;
        end
        // R8: every queued packet was taken
        chk("R8", "left64", 128'(qa.size()), 128'd0);
        chk("R8", "left128", 128'(qb.size()), 128'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule